// File: doc/BRIEF.md
# GPIO Input Glitch Filter

This block cleans up a single general-purpose input that has already been brought into the clock domain. It watches the raw level and produces a filtered level for the trigger logic that follows. An 8-bit setting controls the filter. It sets how many timebase periods a new level must be held, and which of four timebases is used. It also sets which transition directions are filtered and which pass at once.

All four timebases come from one slow reference tick through a shared prescaler, with the divide ratio of each timebase a parameter. With a reference of about 30.5 us, the default ratios 2, 6, 510 and 2046 give roughly 61 us, 183 us, 15.56 ms and 62.44 ms per count. Some example settings: count 5 on the second base is about 1 ms, and count 8 on the fourth is about 500 ms. In a filtered direction the output moves only after the input has stayed at its new level for the whole window. A bounce back to the old level throws away the progress made so far.

Top module: `gpio_debounce`

## Requirements
- R1: When the count field `cfg[3:0]` is zero, any difference between `raw` and `clean` is copied to `clean` on the next clock edge, whatever the other fields hold.
- R2: While `rst_n` is low, each clock edge loads `clean` with `raw` and clears the prescaler and period counter.
- R3: Mode field `cfg[6:5]` = 1 lets a falling transition (raw low while clean high) through on the next edge, and filters a rising one.
- R4: Mode field `cfg[6:5]` = 2 lets a rising transition through on the next edge, and filters a falling one.
- R5: Mode 3 filters both directions, and mode 0 behaves exactly as mode 3.
- R6: The timebase is picked by bits {cfg[7], cfg[4]}: 00 uses TB0_DIV ticks per period, 01 uses TB1_DIV, 10 uses TB2_DIV and 11 uses TB3_DIV.
- R7: In a filtered direction, `clean` takes the new level on the clock edge at which the count × divisor-th `tick` is sampled. Ticks are counted from the first edge at which the difference is seen. With no tick, `clean` holds.
- R8: If `raw` goes back to the level of `clean` before the window ends, `clean` does not change, and a later change starts a full new window.
- R9: A change of `cfg` restarts the window. The tick sampled at the edge where the new value is first seen is not counted.
- R10: While `raw` equals `clean`, `clean` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle reference pulse for the timebases |
| cfg | input | 8 | Filter setting: count [3:0], timebase {7,4}, mode [6:5] |
| raw | input | 1 | Synchronised raw input level |
| clean | output | 1 | Filtered level |

## Verification
The assertions take `raw` and `cfg` to be already synchronous to `clk` and free of unknowns. They also take `tick` to be a single-cycle pulse sampled at clock edges. The bench meets this by changing every input only on the falling edge. It generates `tick` itself as one high cycle in three. Against each raw or configuration change it counts the sampled ticks and cycles, and it does not count a tick on the edge where a new setting takes effect. Glitch lengths are chosen to stay well inside the active window, so an early flip shows up as an unexpected transition.

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int TB0_DIV = 2,
  parameter int TB1_DIV = 6,
  parameter int TB2_DIV = 510,
  parameter int TB3_DIV = 2046
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] cfg,
  input  logic       raw,
  output logic       clean
);

  localparam int M01  = (TB0_DIV > TB1_DIV) ? TB0_DIV : TB1_DIV;
  localparam int M23  = (TB2_DIV > TB3_DIV) ? TB2_DIV : TB3_DIV;
  localparam int DMAX = (M01 > M23) ? M01 : M23;
  localparam int PW   = (DMAX > 1) ? $clog2(DMAX) : 1;

  localparam logic [PW-1:0] LIM0 = PW'(TB0_DIV - 1);
  localparam logic [PW-1:0] LIM1 = PW'(TB1_DIV - 1);
  localparam logic [PW-1:0] LIM2 = PW'(TB2_DIV - 1);
  localparam logic [PW-1:0] LIM3 = PW'(TB3_DIV - 1);

  logic [PW-1:0] pre;
  logic [3:0]    per;
  logic [7:0]    cfg_q;
  logic [PW-1:0] lim;

  wire [3:0] cnt  = cfg[3:0];
  wire [1:0] tb   = {cfg[7], cfg[4]};
  wire [1:0] mode = cfg[6:5];

  always_comb begin
    case (tb)
      2'b00:   lim = LIM0;
      2'b01:   lim = LIM1;
      2'b10:   lim = LIM2;
      default: lim = LIM3;
    endcase
  end

  wire filt_rise  = (mode != 2'd2);
  wire filt_fall  = (mode != 2'd1);
  wire pending    = (raw != clean);
  wire slow       = (cnt != 4'd0) && (raw ? filt_rise : filt_fall);
  wire restart    = (cfg != cfg_q);
  wire period_end = tick && (pre == lim);
  wire win_done   = period_end && ({1'b0, per} + 5'd1 == {1'b0, cnt});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clean <= raw;
      pre   <= '0;
      per   <= '0;
      cfg_q <= cfg;
    end else begin
      cfg_q <= cfg;
      if (pending && !slow) begin
        clean <= raw;
        pre   <= '0;
        per   <= '0;
      end else if (!pending || restart) begin
        pre <= '0;
        per <= '0;
      end else if (tick) begin
        if (period_end) begin
          pre <= '0;
          if (win_done) begin
            clean <= raw;
            per   <= '0;
          end else begin
            per <= per + 4'd1;
          end
        end else begin
          pre <= pre + PW'(1);
        end
      end
    end
  end

  AST_BYPASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 4'd0 && pending) |=> (clean == $past(raw)));  // R1
  AST_FAST_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 4'd0 && mode == 2'd1 && !raw && clean) |=> !clean);  // R3
  AST_FAST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 4'd0 && mode == 2'd2 && raw && !clean) |=> clean);  // R4
  AST_SLOW_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (slow && pending && !tick) |=> $stable(clean));  // R7
  AST_CFG_RESTART_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (slow && pending && restart) |=> $stable(clean));  // R9
  AST_HOLD_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending) |=> $stable(clean));  // R10
  AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    per <= 4'd14);  // R7

endmodule

// File: tb/gpio_debounce_tb.sv
module gpio_debounce_tb;
  localparam int CLK_NS = 10;
  localparam int TICK_EVERY = 3;
  localparam int D0 = 2, D1 = 3, D2 = 4, D3 = 5;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, raw = 1'b1;
  logic [7:0] cfg = 8'h00;
  wire clean;

  gpio_debounce #(.TB0_DIV(D0), .TB1_DIV(D1), .TB2_DIV(D2), .TB3_DIV(D3)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .raw(raw), .clean(clean));

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, errors = 0;
  int tcount = 0, ccount = 0;
  bit skip = 1'b0;
  bit mon_on = 1'b0;
  int tick_ph = 0;

  bit    q_val[$];
  bit    q_imm[$];
  int    q_tk[$];
  string q_req[$];

  initial begin
    forever begin
      @(negedge clk);
      tick_ph = (tick_ph + 1) % TICK_EVERY;
      tick = (tick_ph == 0);
    end
  end

  always @(posedge clk) begin
    if (tick && !skip) tcount++;
    skip = 1'b0;
    ccount++;
  end

  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (mon_on && clean !== prev) begin
        checks++;
        if (q_val.size() == 0) begin
          errors++;
          $display("FAIL R8 unexpected clean change: actual %0b expected %0b", clean, prev);
        end else begin
          bit v; bit im; int tk; string rq;
          v = q_val.pop_front(); im = q_imm.pop_front();
          tk = q_tk.pop_front(); rq = q_req.pop_front();
          if (clean !== v) begin
            errors++;
            $display("FAIL %s level: actual %0b expected %0b", rq, clean, v);
          end else if (im && ccount != 1) begin
            errors++;
            $display("FAIL %s delay cycles: actual %0d expected 1", rq, ccount);
          end else if (!im && tcount != tk) begin
            errors++;
            $display("FAIL %s ticks: actual %0d expected %0d", rq, tcount, tk);
          end
        end
      end
      prev = clean;
    end
  end

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [7:0] mk(input logic [3:0] n, input logic [1:0] t, input logic [1:0] md);
    return {t[1], md, t[0], n};
  endfunction

  task automatic set_cfg(input logic [7:0] c);
    @(negedge clk);
    cfg = c; tcount = 0; skip = 1'b1;
  endtask

  task automatic move(input bit v, input bit imm, input int tk, input string rq);
    @(negedge clk);
    raw = v; tcount = 0; ccount = 0;
    q_val.push_back(v); q_imm.push_back(imm); q_tk.push_back(tk); q_req.push_back(rq);
  endtask

  task automatic glitch(input bit v, input int n);
    @(negedge clk);
    raw = v; tcount = 0; ccount = 0;
    repeat (n) @(negedge clk);
    raw = ~v; tcount = 0; ccount = 0;
  endtask

  task automatic settle();
    while (q_val.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic idle_check(input int n, input string rq);
    repeat (n) @(negedge clk);
    checks++;
    if (q_val.size() != 0) begin
      errors++;
      $display("FAIL %s pending expectations: actual %0d expected 0", rq, q_val.size());
    end
  endtask

  task automatic check_lvl(input bit e, input string rq);
    checks++;
    if (clean !== e) begin
      errors++;
      $display("FAIL %s clean: actual %0b expected %0b", rq, clean, e);
    end
  endtask

  initial begin
    // R2: reset loads raw
    repeat (3) @(negedge clk);
    check_lvl(1'b1, "R2");
    raw = 1'b0;
    @(negedge clk);
    check_lvl(1'b0, "R2");
    raw = 1'b1;
    @(negedge clk);
    check_lvl(1'b1, "R2");
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1: count zero passes through
    move(1'b0, 1'b1, 0, "R1");
    move(1'b1, 1'b1, 0, "R1");
    settle();

    // R5/R6 mode 3, base 00
    set_cfg(mk(4'd2, 2'b00, 2'd3));
    move(1'b0, 1'b0, 2*D0, "R5");
    settle();
    move(1'b1, 1'b0, 2*D0, "R5");
    settle();

    // R3 mode 1, base 01
    set_cfg(mk(4'd3, 2'b01, 2'd1));
    move(1'b0, 1'b1, 0, "R3");
    settle();
    move(1'b1, 1'b0, 3*D1, "R3");
    settle();

    // R4 mode 2, base 10
    set_cfg(mk(4'd2, 2'b10, 2'd2));
    move(1'b0, 1'b0, 2*D2, "R4");
    settle();
    move(1'b1, 1'b1, 0, "R4");
    settle();

    // R5 mode 0 same as 3, R6 base 11
    set_cfg(mk(4'd1, 2'b11, 2'd0));
    move(1'b0, 1'b0, 1*D3, "R6");
    settle();
    move(1'b1, 1'b0, 1*D3, "R5");
    settle();

    // R8 short glitch rejected, later change takes a full window
    set_cfg(mk(4'd3, 2'b00, 2'd3));
    glitch(1'b0, 6);
    idle_check(40, "R8");
    move(1'b0, 1'b0, 3*D0, "R8");
    settle();

    // R3 high glitch filtered, low glitch kept
    set_cfg(mk(4'd3, 2'b01, 2'd1));
    glitch(1'b1, 5);
    idle_check(40, "R3");
    move(1'b1, 1'b0, 3*D1, "R3");
    settle();
    move(1'b0, 1'b1, 0, "R3");
    repeat (1) @(negedge clk);
    move(1'b1, 1'b0, 3*D1, "R3");
    settle();

    // R9 configuration change restarts the window
    set_cfg(mk(4'd2, 2'b00, 2'd3));
    move(1'b0, 1'b0, 2*D1, "R9");
    repeat (2) @(negedge clk);
    set_cfg(mk(4'd2, 2'b01, 2'd3));
    settle();

    // R10 steady input holds output
    idle_check(30, "R10");
    check_lvl(1'b0, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule